// File: doc/BRIEF.md
# Four-Channel Command-Strobe Interval Timer

A bank of up-counting interval timers behind a plain 32-bit register bus. Each channel counts at the rate of its own tick-enable input, compares its count with a programmable terminal value and raises a pending flag when the count expires. In continuous mode the channel wraps to zero and keeps running. In one-shot mode it stops and drops back to idle. The interrupt line of a channel is the pending flag gated by its interrupt enable bit.

Software controls a channel through write-only command locations. Reset, start and stop act on the write itself and ignore the data written. Separate locations hold the mode, the terminal count and the interrupt enable, and an acknowledge location clears the pending flag. A readable status word packs a one-hot state code together with the enable, mode, interrupt-enable and pending flags. One shared register drives a clock-request output.

Each channel is a two-state machine, `ST_IDLE` and `ST_ACTIVE`. A start command takes it from `ST_IDLE` to `ST_ACTIVE` ("arm"). A stop command takes it from `ST_ACTIVE` to `ST_IDLE` ("halt"). A reset command takes either state to `ST_IDLE` with the count cleared ("clear"). A continuous-mode expiry stays in `ST_ACTIVE` ("wrap"). A one-shot expiry goes to `ST_IDLE` ("finish").

Top module: `timer_bank`

## Requirements
- R1: After `rst_n` is released:
  - every channel reads status 0x01, count 0 and terminal count 0xFFFFFFFF;
  - all `irq` bits are 0 and `clk_req` is 0.
- R2: A write of any data to channel offset +0x04 starts the channel. Status then reads:
  - bits [3:0] = 1 when idle and 2 when active;
  - bit 4 set while active;
  - bit 5 set for one-shot mode;
  - bit 6 = interrupt enable;
  - bit 7 = pending.
- R3: The count (offset +0x14) rises by one on each clock edge where the channel is active and its `tick_en` bit is high. Otherwise it holds.
- R4: In continuous mode (bit 0 of offset +0x0C = 0), a tick while the count equals the terminal count (offset +0x18) does three things: the count goes to 0, pending is set, and the channel stays active.
- R5: In one-shot mode (bit 0 = 1), the expiring tick does three things: the count goes to 0, pending is set, and the channel returns to idle, after which ticks have no effect.
- R6: A write to offset +0x00 clears the count and the pending flag and forces idle. Terminal count, mode and interrupt enable keep their values.
- R7: A write to offset +0x08 stops an active channel and holds its count.
- R8: `irq[n]` is high exactly when channel n is pending and bit 0 of its interrupt enable register (offset +0x1C) is 1.
- R9: A write to offset +0x20 with bit 7 set clears pending. A write there with bit 7 clear leaves pending unchanged.
- R10: When an expiry and a clearing acknowledge fall on the same clock edge, pending stays set.
- R11: Channel n occupies the window starting at n*0x40. Commands addressed to one channel leave the other channels' counts and states unchanged.
- R12: Bit 0 of the shared register at 0x100 drives `clk_req` and reads back at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read qualifier for combinational read data |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| tick_en | input | 4 | Per-channel count-rate enable |
| irq | output | 4 | Per-channel interrupt |
| clk_req | output | 1 | Clock request from the shared register |

## Verification
The expiry of a channel and a software acknowledge of that same channel can land on one clock edge. One sets the pending flag and the other clears it. The bench brings a continuous channel to its terminal count. On the next edge it raises the tick and writes the acknowledge together. It then checks through the status word and the `irq` pin that pending survived and the count wrapped to zero. A separate acknowledge on a quiet cycle confirms that the same write clears the flag when no expiry competes.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
    localparam int BUS_W      = 32;
    localparam int WIN_BYTES  = 64;
    localparam int OFS_W      = 6;

    localparam logic [OFS_W-1:0] OFS_CLEAR  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_START  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_STOP   = 6'h08;
    localparam logic [OFS_W-1:0] OFS_MODE   = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_STAT   = 6'h10;
    localparam logic [OFS_W-1:0] OFS_COUNT  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_LIMIT  = 6'h18;
    localparam logic [OFS_W-1:0] OFS_IRQEN  = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_ACK    = 6'h20;

    localparam int ACK_BIT = 7;

    localparam logic [3:0] CODE_IDLE   = 4'h1;
    localparam logic [3:0] CODE_ACTIVE = 4'h2;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } chan_state_e;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_bank_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_clear,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              wr_mode,
    input  logic              wr_limit,
    input  logic              wr_irqen,
    input  logic              wr_ack,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  status_o,
    output logic [CW-1:0]     count_o,
    output logic [CW-1:0]     limit_o,
    output logic              irq_o
);
    chan_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d, lim_q;
    logic          oneshot_q, irqen_q, pend_q, pend_d;
    logic          any_cmd, step, expire, ack_clr;

    assign any_cmd = cmd_clear | cmd_start | cmd_stop;
    assign step    = (st_q == ST_ACTIVE) && tick && !any_cmd;
    assign expire  = step && (cnt_q == lim_q);
    assign ack_clr = wr_ack && wdata[ACK_BIT];

    // next state and count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_clear)      cnt_d = '0;
                else if (cmd_start) st_d  = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (cmd_clear) begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else if (cmd_stop) begin
                    st_d  = ST_IDLE;
                end else if (expire) begin
                    cnt_d = '0;
                    if (oneshot_q) st_d = ST_IDLE;
                end else if (step) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // pending flag: clear command, then expiry, then acknowledge
    always_comb begin
        pend_d = pend_q;
        if (cmd_clear)    pend_d = 1'b0;
        else if (expire)  pend_d = 1'b1;
        else if (ack_clr) pend_d = 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q     <= '1;
            oneshot_q <= 1'b0;
            irqen_q   <= 1'b0;
        end else begin
            if (wr_limit) lim_q     <= wdata[CW-1:0];
            if (wr_mode)  oneshot_q <= wdata[0];
            if (wr_irqen) irqen_q   <= wdata[0];
        end
    end

    // outputs
    always_comb begin
        status_o      = '0;
        status_o[3:0] = (st_q == ST_ACTIVE) ? CODE_ACTIVE : CODE_IDLE;
        status_o[4]   = (st_q == ST_ACTIVE);
        status_o[5]   = oneshot_q;
        status_o[6]   = irqen_q;
        status_o[7]   = pend_q;
        count_o       = cnt_q;
        limit_o       = lim_q;
        irq_o         = pend_q & irqen_q;
    end

    // R3: idle channel holds its count unless cleared
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !cmd_clear) |=> (cnt_q == $past(cnt_q)));

    // R4: continuous expiry wraps and stays active
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !oneshot_q) |=> (cnt_q == '0 && pend_q && st_q == ST_ACTIVE));

    // R5: one-shot expiry returns to idle
    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && oneshot_q) |=> (cnt_q == '0 && pend_q && st_q == ST_IDLE));

    // R6: clear command keeps the terminal count
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (cnt_q == '0 && !pend_q && st_q == ST_IDLE && lim_q == $past(lim_q)));

    // R9: a quiet acknowledge clears pending
    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !expire && !cmd_clear) |=> !pend_q);

    // R10: expiry wins over a same-edge acknowledge
    p_expiry_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ack_clr) |=> pend_q);

    // R2: state code is one-hot
    p_state_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_o[3:0]) == 1);
endmodule

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import timer_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int AW  = 9
) (
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [AW-1:0]              bus_addr,
    input  logic [NCH-1:0][BUS_W-1:0]  ch_status,
    input  logic [NCH-1:0][CW-1:0]     ch_count,
    input  logic [NCH-1:0][CW-1:0]     ch_limit,
    input  logic                       clk_req_q,
    output logic [NCH-1:0]             s_clear,
    output logic [NCH-1:0]             s_start,
    output logic [NCH-1:0]             s_stop,
    output logic [NCH-1:0]             s_mode,
    output logic [NCH-1:0]             s_limit,
    output logic [NCH-1:0]             s_irqen,
    output logic [NCH-1:0]             s_ack,
    output logic                       s_shared,
    output logic [BUS_W-1:0]           rdata
);
    localparam int SELW = AW - OFS_W;
    localparam logic [SELW-1:0] SHARED_SEL = SELW'(NCH);

    logic [SELW-1:0]  sel;
    logic [OFS_W-1:0] ofs;

    assign sel = bus_addr[AW-1:OFS_W];
    assign ofs = bus_addr[OFS_W-1:0];

    assign s_shared = bus_wr && (sel == SHARED_SEL) && (ofs == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        logic hit;
        assign hit        = bus_wr && (sel == SELW'(c));
        assign s_clear[c] = hit && (ofs == OFS_CLEAR);
        assign s_start[c] = hit && (ofs == OFS_START);
        assign s_stop[c]  = hit && (ofs == OFS_STOP);
        assign s_mode[c]  = hit && (ofs == OFS_MODE);
        assign s_limit[c] = hit && (ofs == OFS_LIMIT);
        assign s_irqen[c] = hit && (ofs == OFS_IRQEN);
        assign s_ack[c]   = hit && (ofs == OFS_ACK);
    end

    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            if (sel == SHARED_SEL && ofs == '0) begin
                rdata[0] = clk_req_q;
            end
            for (int c = 0; c < NCH; c++) begin
                if (sel == SELW'(c)) begin
                    if (ofs == OFS_STAT)  rdata = ch_status[c];
                    if (ofs == OFS_COUNT) rdata = BUS_W'(ch_count[c]);
                    if (ofs == OFS_LIMIT) rdata = BUS_W'(ch_limit[c]);
                end
            end
        end
    end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import timer_bank_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int CW  = 32,
    localparam int AW  = $clog2(NCH * WIN_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NCH-1:0]   tick_en,
    output logic [NCH-1:0]   irq,
    output logic             clk_req
);
    logic [NCH-1:0][BUS_W-1:0] ch_status;
    logic [NCH-1:0][CW-1:0]    ch_count, ch_limit;
    logic [NCH-1:0] s_clear, s_start, s_stop, s_mode, s_limit, s_irqen, s_ack;
    logic           s_shared, clk_req_q;

    tmr_regdec #(.NCH(NCH), .CW(CW), .AW(AW)) u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .ch_status (ch_status),
        .ch_count  (ch_count),
        .ch_limit  (ch_limit),
        .clk_req_q (clk_req_q),
        .s_clear   (s_clear),
        .s_start   (s_start),
        .s_stop    (s_stop),
        .s_mode    (s_mode),
        .s_limit   (s_limit),
        .s_irqen   (s_irqen),
        .s_ack     (s_ack),
        .s_shared  (s_shared),
        .rdata     (bus_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_en[c]),
            .cmd_clear (s_clear[c]),
            .cmd_start (s_start[c]),
            .cmd_stop  (s_stop[c]),
            .wr_mode   (s_mode[c]),
            .wr_limit  (s_limit[c]),
            .wr_irqen  (s_irqen[c]),
            .wr_ack    (s_ack[c]),
            .wdata     (bus_wdata),
            .status_o  (ch_status[c]),
            .count_o   (ch_count[c]),
            .limit_o   (ch_limit[c]),
            .irq_o     (irq[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        clk_req_q <= 1'b0;
        else if (s_shared) clk_req_q <= bus_wdata[0];
    end

    assign clk_req = clk_req_q;

    // R12: shared register follows its write
    p_clkreq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        s_shared |=> (clk_req == $past(bus_wdata[0])));
endmodule

// File: tb/tb_timer_bank.sv
module tb_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  tick_en = '0, irq;
    logic        clk_req;
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    timer_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .irq(irq), .clk_req(clk_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [8:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 9'(ch * 64) + ofs; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [8:0] ofs, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 9'(ch * 64) + ofs; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int ch, input int n);
        @(negedge clk);
        tick_en[ch] = 1'b1;
        repeat (n) @(negedge clk);
        tick_en[ch] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            rd(c, 9'h10, d); chk("R1 status", d, 32'h01);
            rd(c, 9'h14, d); chk("R1 count", d, 32'h0);
            rd(c, 9'h18, d); chk("R1 limit", d, 32'hFFFFFFFF);
        end
        chk("R1 irq", {28'b0, irq}, 32'h0);
        chk("R1 clk_req", {31'b0, clk_req}, 32'h0);
    endtask

    task automatic t_count_wrap();
        logic [31:0] d;
        wr(0, 9'h18, 32'd3);
        wr(0, 9'h04, 32'hDEADBEEF);
        rd(0, 9'h10, d); chk("R2 start any data", d, 32'h12);
        ticks(0, 2);
        rd(0, 9'h14, d); chk("R3 two ticks", d, 32'd2);
        repeat (3) @(negedge clk);
        rd(0, 9'h14, d); chk("R3 no tick holds", d, 32'd2);
        ticks(0, 2);
        rd(0, 9'h14, d); chk("R4 wrap count", d, 32'd0);
        rd(0, 9'h10, d); chk("R4 pending active", d, 32'h92);
        chk("R8 irq masked", {31'b0, irq[0]}, 32'h0);
        ticks(0, 1);
        rd(0, 9'h14, d); chk("R4 runs on", d, 32'd1);
        wr(0, 9'h1C, 32'h1);
        chk("R8 irq on", {31'b0, irq[0]}, 32'h1);
        wr(0, 9'h20, 32'h7F);
        chk("R9 bit7 clear ignored", {31'b0, irq[0]}, 32'h1);
        wr(0, 9'h20, 32'h80);
        chk("R9 ack clears", {31'b0, irq[0]}, 32'h0);
        rd(0, 9'h10, d); chk("R9 status", d, 32'h52);
    endtask

    task automatic t_oneshot_clear();
        logic [31:0] d;
        wr(1, 9'h0C, 32'h1);
        wr(1, 9'h18, 32'd2);
        wr(1, 9'h04, 32'h0);
        ticks(1, 5);
        rd(1, 9'h10, d); chk("R5 idle pending", d, 32'hA1);
        rd(1, 9'h14, d); chk("R5 count stays 0", d, 32'd0);
        wr(1, 9'h1C, 32'h1);
        chk("R8 oneshot irq", {31'b0, irq[1]}, 32'h1);
        wr(1, 9'h00, 32'h5);
        rd(1, 9'h10, d); chk("R6 clear keeps cfg", d, 32'h61);
        rd(1, 9'h18, d); chk("R6 limit kept", d, 32'd2);
        chk("R6 irq dropped", {31'b0, irq[1]}, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        wr(2, 9'h18, 32'd1000);
        wr(2, 9'h04, 32'h0);
        ticks(2, 5);
        wr(2, 9'h08, 32'h0);
        ticks(2, 5);
        rd(2, 9'h14, d); chk("R7 held", d, 32'd5);
        rd(2, 9'h10, d); chk("R7 idle", d, 32'h01);
        wr(0, 9'h00, 32'h0);
        wr(3, 9'h04, 32'h0);
        wr(3, 9'h08, 32'h0);
        rd(2, 9'h14, d); chk("R11 other ch count", d, 32'd5);
        rd(0, 9'h14, d); chk("R11 ch0 cleared", d, 32'd0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(3, 9'h18, 32'd3);
        wr(3, 9'h1C, 32'h1);
        wr(3, 9'h04, 32'h0);
        ticks(3, 3);
        rd(3, 9'h14, d); chk("R10 at limit", d, 32'd3);
        @(negedge clk);
        tick_en[3] = 1'b1;
        bus_addr = 9'h0E0; bus_wdata = 32'h80; bus_wr = 1'b1;
        @(negedge clk);
        tick_en[3] = 1'b0; bus_wr = 1'b0;
        rd(3, 9'h10, d); chk("R10 pending survives", d, 32'hD2);
        rd(3, 9'h14, d); chk("R10 wrapped", d, 32'd0);
        chk("R10 irq", {31'b0, irq[3]}, 32'h1);
    endtask

    task automatic t_shared();
        logic [31:0] d;
        wr(4, 9'h00, 32'h1);
        chk("R12 clk_req set", {31'b0, clk_req}, 32'h1);
        rd(4, 9'h00, d); chk("R12 readback", d, 32'h1);
        wr(4, 9'h00, 32'h0);
        chk("R12 clk_req clear", {31'b0, clk_req}, 32'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog got=%0d exp<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count_wrap();
        t_oneshot_clear();
        t_stop();
        t_collision();
        t_shared();
        done = 1;
        finish_run();
    end
endmodule